// File: doc/BRIEF.md
# Programmable Interval Timer Channel

This block is a single 16-bit down-counting timer channel. A bus unit writes a control word carrying a 3-bit operating mode, then writes an initial count. After that, the channel counts input clocks and drives a single output line, `outLvl`, whose waveform depends on the mode. The modes are an interrupt on terminal count, a one-shot that a gate edge can retrigger, a divide-by-N rate generator, a square-wave generator, a strobe started by the count write, and a strobe started by a gate edge.

The `gate` input either pauses counting or starts it, depending on the mode. The channel shows its live count, its output level and a flag that says a written count is still waiting to be transferred into the counting element. A separate bus unit can latch these values for readback. Counting is binary only. A written count of 0 stands for 65536.

Top module: `tmr_channel`

## Requirements
- R1: After reset, the mode is 0, `outLvl` is 0, `nullCount` is 1 and `curCount` is 0.
- R2: A `modeWr` pulse loads `modeSel` as the mode. Codes 0 to 5 select modes 0 to 5, and codes 6 and 7 behave as modes 2 and 3. The pulse drives `outLvl` to 0 for mode 0 and to 1 for every other mode, sets `nullCount` and stops counting until a count is written.
- R3: A `countWr` pulse sets `nullCount` on its edge. `nullCount` clears on the edge that transfers the written value into the counter.
- R4: In mode 0, `outLvl` falls on the `countWr` edge E0 and the counter loads on edge E1. With gate high, `outLvl` rises on edge E(N+1), when the count reaches 0, and stays high until the next write.
- R5: In modes 0, 2, 3 and 4, a low `gate` holds the count. Counting resumes once `gate` is high again.
- R6: In mode 1, the clock edge that sees `gate` rise loads N and drives `outLvl` low. `outLvl` returns high N edges later. Each later gate rise retriggers the pulse.
- R7: In mode 1, a count written during an active pulse leaves that pulse unchanged. It is used on the next trigger.
- R8: In mode 2, the period is N clocks. `outLvl` is low for exactly the one clock in which the count is 1, and the counter then reloads.
- R9: In mode 3, the period is N clocks. `outLvl` is high for ceil(N/2) clocks and low for floor(N/2) clocks.
- R10: In mode 4, the counter loads on E1. `outLvl` is low for the single clock after edge E(N+1), and no further pulse follows without a new write.
- R11: In mode 5, a gate rise loads N. `outLvl` is low for one clock N edges later. The next gate rise re-arms the strobe.
- R12: A count of 0 acts as 65536. In mode 0, `outLvl` rises on edge E65537.
- R13: In modes 2 and 3, a low `gate` forces `outLvl` high. The next gate rise reloads the count.
- R14: In modes 2 and 3, a count written while the counter is running takes effect at the next reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counting clock |
| rstN | input | 1 | Active-low synchronous reset |
| modeWr | input | 1 | Control word write strobe |
| modeSel | input | 3 | Mode field of the control word |
| countWr | input | 1 | Initial count write strobe |
| countIn | input | 16 | Initial count value |
| gate | input | 1 | Gate / trigger input |
| outLvl | output | 1 | Timer output line |
| curCount | output | 16 | Current contents of the counting element |
| nullCount | output | 1 | Written count not yet transferred |

## Verification
A wrong reload value or load edge shows on `curCount` at the very next clock edge after the transfer. `nullCount` also stays high one clock too long. A mistake in the phase or terminal-count logic shows on `outLvl` within one period of N clocks. In the strobe modes it shows as a second pulse or a missing pulse. A fault in the gate edge detection shows as a load that arrives one clock late or never, visible at the first trigger.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  typedef enum logic [2:0] {
    MODE_TC_IRQ    = 3'd0,
    MODE_ONESHOT   = 3'd1,
    MODE_RATE      = 3'd2,
    MODE_SQUARE    = 3'd3,
    MODE_SW_STROBE = 3'd4,
    MODE_HW_STROBE = 3'd5
  } tmrMode_e;

  // control -> datapath strobes
  typedef struct packed {
    logic load;
    logic dec;
  } cntStrobe_t;

  function automatic tmrMode_e normMode(input logic [2:0] sel);
    case (sel)
      3'd6:    return MODE_RATE;
      3'd7:    return MODE_SQUARE;
      default: return tmrMode_e'(sel);
    endcase
  endfunction

endpackage

// File: rtl/tmr_datapath.sv
module tmr_datapath #(
  parameter int CNT_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  tmr_pkg::cntStrobe_t strobe,
  input  logic [CNT_W-1:0]    loadVal,
  output logic [CNT_W-1:0]    cnt,
  output logic                cntIsOne,
  output logic                cntIsTwo
);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (strobe.load) begin
      cnt <= loadVal;
    end else if (strobe.dec) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign cntIsOne = (cnt == CNT_W'(1));
  assign cntIsTwo = (cnt == CNT_W'(2));

endmodule

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             modeWr,
  input  logic [2:0]       modeSel,
  input  logic             countWr,
  input  logic [CNT_W-1:0] countIn,
  input  logic             gate,
  input  logic [CNT_W-1:0] cnt,
  input  logic             cntIsOne,
  input  logic             cntIsTwo,
  output cntStrobe_t       strobe,
  output logic [CNT_W-1:0] loadVal,
  output logic             outLvl,
  output logic             nullCount
);

  localparam int EXT_W = CNT_W + 1;

  tmrMode_e         modeQ;
  logic [CNT_W-1:0] crQ;
  logic [EXT_W-1:0] periodQ;
  logic             crValid, pending, running, done, outQ, nullQ, gatePrev;

  logic             rise, load, dec, tc, outN;
  logic [CNT_W-1:0] cntDec;
  logic [EXT_W-1:0] nextExt;

  assign rise    = gate & ~gatePrev;
  assign cntDec  = cnt - 1'b1;
  assign nextExt = {1'b0, cntDec};

  // load / decrement decisions
  always_comb begin
    load = 1'b0;
    dec  = 1'b0;
    case (modeQ)
      MODE_TC_IRQ, MODE_SW_STROBE: begin
        load = pending;
        dec  = running & gate & ~pending;
      end
      MODE_ONESHOT, MODE_HW_STROBE: begin
        load = rise & crValid;
        dec  = running & ~load;
      end
      MODE_RATE, MODE_SQUARE: begin
        load = pending | (crValid & rise) | (running & gate & cntIsOne);
        dec  = running & gate & ~load;
      end
      default: begin
        load = 1'b0;
        dec  = 1'b0;
      end
    endcase
  end

  assign tc = dec & cntIsOne;

  // output waveform per mode
  always_comb begin
    outN = outQ;
    case (modeQ)
      MODE_TC_IRQ: begin
        if (tc) outN = 1'b1;
      end
      MODE_ONESHOT: begin
        if (load)    outN = 1'b0;
        else if (tc) outN = 1'b1;
      end
      MODE_RATE: begin
        if (!gate)                outN = 1'b1;
        else if (load)            outN = 1'b1;
        else if (dec && cntIsTwo) outN = 1'b0;
      end
      MODE_SQUARE: begin
        if (!gate)     outN = 1'b1;
        else if (load) outN = 1'b1;
        else if (dec)  outN = (nextExt > (periodQ >> 1));
      end
      MODE_SW_STROBE, MODE_HW_STROBE: begin
        outN = ~(tc & ~done);
      end
      default: outN = outQ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ    <= MODE_TC_IRQ;
      crQ      <= '0;
      periodQ  <= '0;
      crValid  <= 1'b0;
      pending  <= 1'b0;
      running  <= 1'b0;
      done     <= 1'b0;
      outQ     <= 1'b0;
      nullQ    <= 1'b1;
      gatePrev <= 1'b0;
    end else begin
      gatePrev <= gate;
      if (modeWr) begin
        modeQ   <= normMode(modeSel);
        outQ    <= (normMode(modeSel) != MODE_TC_IRQ);
        crValid <= 1'b0;
        pending <= 1'b0;
        running <= 1'b0;
        done    <= 1'b0;
        nullQ   <= 1'b1;
      end else begin
        outQ <= outN;
        if (load) begin
          running <= 1'b1;
          pending <= 1'b0;
          done    <= 1'b0;
          periodQ <= {crQ == '0, crQ};
          nullQ   <= 1'b0;
        end
        if (tc) done <= 1'b1;
        if (countWr) begin
          crQ     <= countIn;
          crValid <= 1'b1;
          nullQ   <= 1'b1;
          if (modeQ == MODE_TC_IRQ) outQ <= 1'b0;
          if (modeQ == MODE_TC_IRQ || modeQ == MODE_SW_STROBE ||
              ((modeQ == MODE_RATE || modeQ == MODE_SQUARE) && !running))
            pending <= 1'b1;
        end
      end
    end
  end

  assign strobe.load = load;
  assign strobe.dec  = dec;
  assign loadVal     = crQ;
  assign outLvl      = outQ;
  assign nullCount   = nullQ;

  // ---------------- assertions ----------------
  assert_null_clear_R3: assert property (@(posedge clk) disable iff (!rstN)
    (load && !countWr && !modeWr) |=> !nullQ);

  assert_tc_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ == MODE_TC_IRQ && outQ && !modeWr && !countWr) |=> outQ);

  assert_gate_pause_R5: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ == MODE_TC_IRQ && !gate && !pending && !modeWr) |=> $stable(cnt));

  assert_oneshot_write_R7: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ == MODE_ONESHOT && countWr && !load && !tc && !modeWr) |=> (outQ == $past(outQ)));

  assert_rate_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ == MODE_RATE && !outQ && !modeWr) |=> outQ);

  // covers R11 as well (mode 5 shares the strobe shape)
  assert_strobe_pulse_R10: assert property (@(posedge clk) disable iff (!rstN)
    ((modeQ == MODE_SW_STROBE || modeQ == MODE_HW_STROBE) && !outQ && !modeWr) |=> outQ);

  assert_gate_high_R13: assert property (@(posedge clk) disable iff (!rstN)
    ((modeQ == MODE_RATE || modeQ == MODE_SQUARE) && !gate && !modeWr) |=> outQ);

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             modeWr,
  input  logic [2:0]       modeSel,
  input  logic             countWr,
  input  logic [CNT_W-1:0] countIn,
  input  logic             gate,
  output logic             outLvl,
  output logic [CNT_W-1:0] curCount,
  output logic             nullCount
);

  tmr_pkg::cntStrobe_t strobe;
  logic [CNT_W-1:0]    loadVal;
  logic                cntIsOne, cntIsTwo;

  tmr_ctrl #(.CNT_W(CNT_W)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .modeWr   (modeWr),
    .modeSel  (modeSel),
    .countWr  (countWr),
    .countIn  (countIn),
    .gate     (gate),
    .cnt      (curCount),
    .cntIsOne (cntIsOne),
    .cntIsTwo (cntIsTwo),
    .strobe   (strobe),
    .loadVal  (loadVal),
    .outLvl   (outLvl),
    .nullCount(nullCount)
  );

  tmr_datapath #(.CNT_W(CNT_W)) uData (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .loadVal (loadVal),
    .cnt     (curCount),
    .cntIsOne(cntIsOne),
    .cntIsTwo(cntIsTwo)
  );

endmodule

// File: tb/sim_tmr_channel.sv
`timescale 1ns/1ps
module sim_tmr_channel;

  logic        clk = 1'b0;
  logic        rstN, modeWr, countWr, gate;
  logic [2:0]  modeSel;
  logic [15:0] countIn;
  logic        outLvl, nullCount;
  logic [15:0] curCount;

  int vecs = 0;
  int errs = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  tmr_channel u0 (
    .clk(clk), .rstN(rstN), .modeWr(modeWr), .modeSel(modeSel),
    .countWr(countWr), .countIn(countIn), .gate(gate),
    .outLvl(outLvl), .curCount(curCount), .nullCount(nullCount)
  );

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic setMode(input int m);
    modeSel = m[2:0];
    modeWr  = 1'b1;
    tick();
    modeWr  = 1'b0;
  endtask

  task automatic loadCount(input int n);
    countIn = n[15:0];
    countWr = 1'b1;
    tick();
    countWr = 1'b0;
  endtask

  // expected-value functions; i counts edges after the count-write edge
  function automatic int expDown(input int n, input int steps);
    return (n - steps) & 32'hFFFF;
  endfunction
  function automatic int rateCnt(input int n, input int i);
    return n - ((i - 1) % n);
  endfunction
  function automatic int rateOut(input int n, input int i);
    return (((i - 1) % n) != n - 1) ? 1 : 0;
  endfunction
  function automatic int squareOut(input int n, input int i);
    return (rateCnt(n, i) > n / 2) ? 1 : 0;
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      errs++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    int n;
    void'($urandom(32'd2024));
    rstN = 1'b0; modeWr = 1'b0; countWr = 1'b0; gate = 1'b1;
    modeSel = '0; countIn = '0;
    repeat (3) tick();
    chk("R1 out", outLvl, 0);
    chk("R1 null", nullCount, 1);
    chk("R1 count", curCount, 0);
    rstN = 1'b1;
    tick();

    // R2: mode write levels, code 6 maps to rate mode
    setMode(6);
    chk("R2 out after mode6", outLvl, 1);
    chk("R2 null after mode", nullCount, 1);
    setMode(0);
    chk("R2 out after mode0", outLvl, 0);

    // R4 / R3: mode 0 random counts
    for (int r = 0; r < 3; r++) begin
      n = 1 + int'($urandom % 30);
      setMode(0);
      loadCount(n);
      chk("R4 out low on write", outLvl, 0);
      chk("R3 null set", nullCount, 1);
      for (int i = 1; i <= n + 2; i++) begin
        tick();
        if (i == 1) chk("R3 null cleared", nullCount, 0);
        chk("R4 count", curCount, expDown(n, i - 1));
        chk("R4 out", outLvl, (i >= n + 1) ? 1 : 0);
      end
    end

    // R5: gate pause in mode 0
    setMode(0);
    loadCount(10);
    repeat (3) tick();
    gate = 1'b0;
    for (int k = 0; k < 4; k++) begin
      tick();
      chk("R5 held count", curCount, 8);
    end
    gate = 1'b1;
    tick();
    chk("R5 resumed count", curCount, 7);

    // R6: mode 1 trigger and retrigger
    n = 2 + int'($urandom % 19);
    setMode(1);
    gate = 1'b0;
    loadCount(n);
    tick();
    chk("R6 idle out", outLvl, 1);
    chk("R6 not loaded null", nullCount, 1);
    gate = 1'b1;
    tick();
    chk("R6 trigger out", outLvl, 0);
    chk("R6 trigger count", curCount, n);
    for (int j = 1; j <= n + 1; j++) begin
      tick();
      chk("R6 pulse out", outLvl, (j >= n) ? 1 : 0);
      chk("R6 pulse count", curCount, expDown(n, j));
    end
    gate = 1'b0; tick();
    gate = 1'b1; tick();
    chk("R6 retrigger out", outLvl, 0);
    chk("R6 retrigger count", curCount, n);

    // R7: write during one-shot pulse
    setMode(1);
    loadCount(8);
    gate = 1'b0; tick();
    gate = 1'b1; tick();
    tick(); tick();
    countIn = 16'd5; countWr = 1'b1; tick(); countWr = 1'b0;
    chk("R7 out unchanged", outLvl, 0);
    chk("R7 null pending", nullCount, 1);
    chk("R7 count unchanged", curCount, 5);
    for (int j = 4; j <= 8; j++) begin
      tick();
      chk("R7 pulse out", outLvl, (j >= 8) ? 1 : 0);
    end
    chk("R7 end count", curCount, 0);
    gate = 1'b0; tick();
    gate = 1'b1; tick();
    chk("R7 new count used", curCount, 5);
    chk("R7 null cleared", nullCount, 0);

    // R8: rate generator, random counts, then code 6
    for (int r = 0; r < 4; r++) begin
      n = (r == 3) ? 3 : 2 + int'($urandom % 19);
      setMode((r == 3) ? 6 : 2);
      loadCount(n);
      for (int i = 1; i <= 3 * n + 1; i++) begin
        tick();
        chk("R8 count", curCount, rateCnt(n, i));
        chk("R8 out", outLvl, rateOut(n, i));
      end
    end

    // R14: new count in mode 2 at next reload
    setMode(2);
    loadCount(6);
    tick(); tick();
    countIn = 16'd4; countWr = 1'b1; tick(); countWr = 1'b0;
    chk("R14 count continues", curCount, 4);
    chk("R14 null set", nullCount, 1);
    tick(); tick(); tick();
    chk("R14 low at one", outLvl, 0);
    chk("R14 count one", curCount, 1);
    chk("R14 null still set", nullCount, 1);
    tick();
    chk("R14 reload value", curCount, 4);
    chk("R14 out high", outLvl, 1);
    chk("R14 null cleared", nullCount, 0);

    // R13: gate low in mode 2
    setMode(2);
    loadCount(5);
    tick(); tick();
    gate = 1'b0;
    for (int k = 0; k < 3; k++) begin
      tick();
      chk("R13 held count", curCount, 4);
      chk("R13 forced high", outLvl, 1);
    end
    gate = 1'b1;
    tick();
    chk("R13 reload on rise", curCount, 5);
    chk("R13 out high", outLvl, 1);
    tick();
    chk("R13 counting again", curCount, 4);

    // R9: square wave, random counts, then code 7 with odd count
    for (int r = 0; r < 4; r++) begin
      n = (r == 3) ? 5 : 2 + int'($urandom % 20);
      setMode((r == 3) ? 7 : 3);
      loadCount(n);
      for (int i = 1; i <= 3 * n + 1; i++) begin
        tick();
        chk("R9 count", curCount, rateCnt(n, i));
        chk("R9 out", outLvl, squareOut(n, i));
      end
    end

    // R10: software strobe
    for (int r = 0; r < 2; r++) begin
      n = 1 + int'($urandom % 20);
      setMode(4);
      loadCount(n);
      for (int i = 1; i <= n + 5; i++) begin
        tick();
        if (i <= n + 1) chk("R10 count", curCount, expDown(n, i - 1));
        chk("R10 out", outLvl, (i == n + 1) ? 0 : 1);
      end
    end

    // R11: hardware strobe, trigger twice
    n = 2 + int'($urandom % 15);
    setMode(5);
    gate = 1'b0;
    loadCount(n);
    tick();
    chk("R11 idle out", outLvl, 1);
    for (int r = 0; r < 2; r++) begin
      gate = 1'b1;
      tick();
      chk("R11 trigger count", curCount, n);
      chk("R11 trigger out", outLvl, 1);
      for (int j = 1; j <= n + 2; j++) begin
        tick();
        if (j <= n) chk("R11 count", curCount, n - j);
        chk("R11 out", outLvl, (j == n) ? 0 : 1);
      end
      gate = 1'b0;
      tick();
    end
    gate = 1'b1;

    // R12: count of zero as 65536 in mode 0
    setMode(0);
    loadCount(0);
    tick();
    chk("R12 loaded zero", curCount, 0);
    chk("R12 out low", outLvl, 0);
    tick();
    chk("R12 wraps", curCount, 16'hFFFF);
    repeat (65533) tick();
    tick();
    chk("R12 count one", curCount, 1);
    chk("R12 still low", outLvl, 0);
    tick();
    chk("R12 count zero", curCount, 0);
    chk("R12 out high", outLvl, 1);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

endmodule